// File: doc/BRIEF.md
# Shared-Bus Tuning Word Serializer

This block lets a host program several tunable elements that share one serial clock line and one serial data line. Each element has its own enable line, which works as a chip select. The host hands over a device index, a 5-bit tuning state and a standby flag through a valid/ready handshake. The block then builds an 8-bit command word and shifts it out MSB first, framed by the enable of the chosen device. Targets therefore take their new settings one after another, in the order the host issues requests.

All serial timing comes from the system clock. Four counts, each set as a parameter in system-clock cycles, control the frame: the half period of the serial clock, the enable-to-first-rising-edge setup, the enable hold after the last falling edge, and the minimum enable-low gap between frames. A one-cycle done pulse marks the end of each frame, once the gap has elapsed. The handshake is ready again in that same cycle.

Top module: `tune_bus_master`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ser_clk`, `ser_dat`, every `dev_en` line and `done` are 0, and `req_ready` is 1.
- R2: A request is taken only while `req_ready` is 1. From the cycle after acceptance until the done pulse, `req_ready` is 0. A `req_valid` raised during that time starts no frame and does not change the word being sent.
- R3: During a frame only the enable bit whose position equals `req_dev` is 1. At most one enable line is ever high.
- R4: The frame carries exactly 8 bits, MSB first, each one the value of `ser_dat` while `ser_clk` is high. The bits are two zeros, then the standby flag, then `req_state[4]` down to `req_state[0]`.
- R5: The selected enable is high for exactly SETUP_CYC system cycles with `ser_clk` low before the first rising edge of `ser_clk`.
- R6: Each high phase and each low phase between rising edges of `ser_clk` lasts exactly HALF_CYC system cycles. A frame has exactly 8 rising edges.
- R7: `ser_dat` never changes while `ser_clk` stays high. It changes only in the cycle `ser_clk` falls, or while it is low.
- R8: After the last falling edge of `ser_clk`, the enable stays high for exactly HOLD_CYC cycles before it drops.
- R9: After the enable drops, all enables stay low for exactly GAP_CYC cycles. `done` is then high for exactly one cycle, together with `req_ready` returning to 1.
- R10: `ser_clk` is low whenever no enable line is high, and it is low again after each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_dev | input | IDX_W | Index of the target device |
| req_state | input | 5 | Tuning state to program |
| req_stby | input | 1 | Standby flag (1 = standby) |
| ser_clk | output | 1 | Shared serial clock, idles low |
| ser_dat | output | 1 | Shared serial data |
| dev_en | output | NUM_DEV | One enable line per device, active high |
| done | output | 1 | One-cycle pulse after the inter-frame gap |

## Verification
The hardest case to reach from the ports is a new request that arrives while a frame is half shifted out. It must neither restart the frame, nor select a second device, nor corrupt the word. The stimulus raises `req_valid` with a different device index right after the third rising edge of `ser_clk`. The bench then checks that the captured word still matches, that only the original enable was high, and that no second frame starts after done. A reset asserted partway through a frame, followed by a clean frame, covers recovery from an aborted transfer.

// File: rtl/tbm_pkg.sv
// Package: shared phase encoding and command word builder for the tuning
// bus serializer. Assumes an 8-bit word with a 5-bit state field.
package tbm_pkg;
    localparam int WORD_W  = 8;
    localparam int STATE_W = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_LOW,
        PH_HOLD,
        PH_GAP
    } phase_t;

    // Command word: two zero bits on top, then standby flag, then state.
    function automatic logic [WORD_W-1:0] make_word(input logic stby,
                                                    input logic [STATE_W-1:0] st);
        return {2'b00, stby, st};
    endfunction

    // Largest of four cycle counts, used to size the shared timer.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/tbm_timer.sv
// Module: loadable down counter shared by all timed phases.
// Assumes: a load sets the count to N-1, so that expired appears after N
// cycles. With no load pending, the count holds at zero.
module tbm_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Count down toward zero; a load restarts the interval.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/tbm_shifter.sv
// Module: MSB-first output shift register with a count of the bits sent.
// Assumes: a load and a shift never happen in the same cycle. The clear
// returns the data line to 0 between frames.
module tbm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    input  logic         clear,
    output logic         dout,
    output logic         last_bit
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sr_q;
    logic [CW-1:0] idx_q;

    // Hold the word; advance one bit per shift request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= din;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= {sr_q[W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign dout     = sr_q[W-1];
    assign last_bit = (idx_q == CW'(W-1));
endmodule

// File: rtl/tbm_enable_dec.sv
// Module: one registered enable per device, set at frame open for the
// selected index and cleared at frame close.
// Assumes: open and close never happen in the same cycle.
module tbm_enable_dec #(
    parameter int NUM_DEV = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open,
    input  logic               close,
    input  logic [IDX_W-1:0]   sel,
    output logic [NUM_DEV-1:0] en
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_en
        // Enable i follows the frame only when this device is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                           en[i] <= 1'b0;
            else if (open && (sel == IDX_W'(i)))  en[i] <= 1'b1;
            else if (close)                       en[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tune_bus_master.sv
// Module: host-side serializer for tunable elements on a shared clock and
// data bus with one enable per device. Takes a valid/ready request and
// sends one 8-bit word MSB first. Enable setup, clock half period, enable
// hold and enable-low gap are counted in system cycles.
// Assumes: every cycle count is at least 1 and req_dev < NUM_DEV.
module tune_bus_master
    import tbm_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int HALF_CYC  = 5,
    parameter int SETUP_CYC = 5,
    parameter int HOLD_CYC  = 5,
    parameter int GAP_CYC   = 10,
    localparam int IDX_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   req_dev,
    input  logic [4:0]         req_state,
    input  logic               req_stby,
    output logic               ser_clk,
    output logic               ser_dat,
    output logic [NUM_DEV-1:0] dev_en,
    output logic               done
);
    localparam int MAXC = max4(HALF_CYC, SETUP_CYC, HOLD_CYC, GAP_CYC);
    localparam int TW   = $clog2(MAXC + 1);

    phase_t          phase_q, phase_d;
    logic            sclk_q, sclk_d;
    logic            done_q, done_d;
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_exp;
    logic            accept, open_f, close_f, do_shift, do_clear;
    logic            last_bit;

    // Phase sequencing: idle, setup, clock high/low pairs, hold, gap.
    always_comb begin
        phase_d  = phase_q;
        sclk_d   = sclk_q;
        done_d   = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        accept   = 1'b0;
        open_f   = 1'b0;
        close_f  = 1'b0;
        do_shift = 1'b0;
        do_clear = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (req_valid) begin
                accept  = 1'b1;
                open_f  = 1'b1;
                phase_d = PH_SETUP;
                t_load  = 1'b1;
                t_val   = TW'(SETUP_CYC - 1);
            end
            PH_SETUP: if (t_exp) begin
                phase_d = PH_HIGH;
                sclk_d  = 1'b1;
                t_load  = 1'b1;
                t_val   = TW'(HALF_CYC - 1);
            end
            PH_HIGH: if (t_exp) begin
                sclk_d = 1'b0;
                t_load = 1'b1;
                if (last_bit) begin
                    phase_d = PH_HOLD;
                    t_val   = TW'(HOLD_CYC - 1);
                end else begin
                    phase_d  = PH_LOW;
                    do_shift = 1'b1;
                    t_val    = TW'(HALF_CYC - 1);
                end
            end
            PH_LOW: if (t_exp) begin
                phase_d = PH_HIGH;
                sclk_d  = 1'b1;
                t_load  = 1'b1;
                t_val   = TW'(HALF_CYC - 1);
            end
            PH_HOLD: if (t_exp) begin
                close_f  = 1'b1;
                do_clear = 1'b1;
                phase_d  = PH_GAP;
                t_load   = 1'b1;
                t_val    = TW'(GAP_CYC - 1);
            end
            PH_GAP: if (t_exp) begin
                phase_d = PH_IDLE;
                done_d  = 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Register phase, serial clock and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            sclk_q  <= sclk_d;
            done_q  <= done_d;
        end
    end

    tbm_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    tbm_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .din      (make_word(req_stby, req_state)),
        .shift    (do_shift),
        .clear    (do_clear),
        .dout     (ser_dat),
        .last_bit (last_bit)
    );

    tbm_enable_dec #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .open  (open_f),
        .close (close_f),
        .sel   (req_dev),
        .en    (dev_en)
    );

    assign req_ready = (phase_q == PH_IDLE);
    assign ser_clk   = sclk_q;
    assign done      = done_q;

    // R3: never more than one device selected.
    a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_en));
    // R10: serial clock only toggles inside a framed transfer.
    a_r10_clock_framed: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> (|dev_en));
    // R7: data held steady through each high phase.
    a_r7_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));
    // R2: no handshake while any enable is high.
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_en) |-> !req_ready);
    // R9: done lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: an enable rises while the clock is still low.
    a_r5_enable_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dev_en) |-> !ser_clk);
endmodule

// File: tb/test_tune_bus_master.sv
module test_tune_bus_master;
    localparam int NDEV  = 4;
    localparam int HALF  = 5;
    localparam int SETUP = 5;
    localparam int HOLD  = 5;
    localparam int GAP   = 10;

    // Vector: [15:14] device, [13] standby, [12:8] state, [7:0] expected word
    localparam logic [15:0] VEC [8] = '{
        16'h0000, 16'h5F1F, 16'hA020, 16'hFF3F,
        16'h1515, 16'h6A2A, 16'h8101, 16'hF030
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_dev = '0;
    logic [4:0]      req_state = '0;
    logic            req_stby = 1'b0;
    logic            ser_clk, ser_dat, done;
    logic [NDEV-1:0] dev_en;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    tune_bus_master #(
        .NUM_DEV(NDEV), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
        .HOLD_CYC(HOLD), .GAP_CYC(GAP)
    ) i_tune_bus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_state(req_state), .req_stby(req_stby),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .dev_en(dev_en), .done(done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(ser_clk == 1'b0, {req, " ser_clk idle"}, int'(ser_clk), 0);
        check(dev_en == '0, {req, " enables idle"}, int'(dev_en), 0);
        check(ser_dat == 1'b0, {req, " ser_dat idle"}, int'(ser_dat), 0);
        check(done == 1'b0, {req, " done idle"}, int'(done), 0);
        check(req_ready == 1'b1, {req, " ready idle"}, int'(req_ready), 1);
    endtask

    // Send one request and measure the whole frame at falling clock edges.
    task automatic do_frame(input logic [1:0] dev, input logic stby,
                            input logic [4:0] st, input logic [7:0] expw,
                            input bit inject);
        logic [7:0] bits = '0;
        int  rises = 0, run = 0, setup_n = 0, hold_n = 0, gap_n = 0;
        int  bad_w = 0, bad_sel = 0, bad_d = 0, bad_rdy = 0, inj_left = 0;
        bit  injected = 0, seen_done = 0;
        logic prev_clk = 1'b0, prev_dat = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        req_dev = dev; req_stby = stby; req_state = st; req_valid = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (inject && inj_left > 0) begin
                inj_left--;
                if (inj_left == 0) req_valid = 1'b0;
            end
            if (inject && !injected && rises == 3) begin
                injected = 1;
                req_dev = dev + 2'd1; req_stby = ~stby; req_state = ~st;
                req_valid = 1'b1; inj_left = 3;
            end
            if (dev_en != '0 && dev_en != (NDEV'(1) << dev)) bad_sel++;
            if (ser_clk && prev_clk && ser_dat != prev_dat) bad_d++;
            if (!done && req_ready) bad_rdy++;
            if (ser_clk != prev_clk) begin
                if (prev_clk) begin
                    if (run != HALF) bad_w++;
                end else if (rises > 0) begin
                    if (run != HALF) bad_w++;
                end
                if (ser_clk) begin
                    rises++;
                    bits = {bits[6:0], ser_dat};
                end
                run = 1;
            end else run++;
            if (dev_en != '0 && !ser_clk && rises == 0) setup_n++;
            if (dev_en != '0 && !ser_clk && rises == 8) hold_n++;
            if (dev_en == '0 && rises == 8 && !done) gap_n++;
            prev_clk = ser_clk;
            prev_dat = ser_dat;
            if (done) begin
                seen_done = 1;
                break;
            end
        end
        req_valid = 1'b0;
        check(seen_done, "R9 done reached", int'(seen_done), 1);
        check(bits == expw, "R4 word bits", int'(bits), int'(expw));
        check(rises == 8, "R6 rising edge count", rises, 8);
        check(bad_w == 0, "R6 phase widths", bad_w, 0);
        check(setup_n == SETUP, "R5 enable setup", setup_n, SETUP);
        check(hold_n == HOLD, "R8 enable hold", hold_n, HOLD);
        check(gap_n == GAP, "R9 enable-low gap", gap_n, GAP);
        check(bad_sel == 0, "R3 only selected enable", bad_sel, 0);
        check(bad_d == 0, "R7 data steady while high", bad_d, 0);
        check(bad_rdy == 0, "R2 ready low while busy", bad_rdy, 0);
        check(req_ready == 1'b1, "R9 ready with done", int'(req_ready), 1);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", int'(done), 0);
        check(ser_clk == 1'b0, "R10 clock low after frame", int'(ser_clk), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // Table-driven frames across devices, states and standby values.
        for (int v = 0; v < 8; v++) begin
            do_frame(VEC[v][15:14], VEC[v][13], VEC[v][12:8], VEC[v][7:0], 1'b0);
        end

        // R2: a request raised mid-frame is ignored.
        do_frame(2'd2, 1'b1, 5'b10110, 8'h36, 1'b1);
        repeat (6) begin
            @(negedge clk);
            check(dev_en == '0, "R2 no frame from ignored request", int'(dev_en), 0);
        end

        // R1: reset in the middle of a frame returns to idle.
        @(negedge clk);
        req_dev = 2'd3; req_stby = 1'b0; req_state = 5'b11001; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-frame reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after mid-frame reset");
        do_frame(2'd1, 1'b0, 5'b01101, 8'h0D, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule